// File: doc/BRIEF.md
# Dual-Compare Up-Counter Timer with Selectable Clear

This block is an up-counting timer with two compare registers, an overflow detector and three sticky event flags. It counts one step on every clock cycle in which its count-enable input is high. When the count equals compare register A or compare register B on a counting cycle, the matching flag is set. When the count wraps from all ones to zero, the overflow flag is set. Each flag drives its own level interrupt line, and each line has its own enable bit in the control register.

A two-bit clear-mode field in the control register selects how the count returns to zero. The count can run freely, restart after a match on A, restart after a match on B, or restart on a rising edge of an external asynchronous pin. The pin passes through a synchroniser and an edge detector before it is used.

Software reaches the control, status, count and both compare registers over a small register bus. Writes take effect in one clock cycle. Reads return data combinationally. A flag is cleared by a read-then-write-zero sequence.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x00, the count reads 0x00, both compare registers read 0xFF, and all three interrupt outputs are low.
- R2: With clear mode 00, the count rises by one at each clock edge where `cnt_en` is high, wraps from 0xFF to 0x00, and holds while `cnt_en` is low.
- R3: On a counting cycle where the count equals compare A, status bit 6 is set at that edge. On a counting cycle where the count equals compare B, status bit 7 is set.
- R4: A counting step from 0xFF to 0x00 sets status bit 5, the overflow flag.
- R5: With control bits 4:3 = 01, a counting cycle with a match on compare A loads 0x00 instead of the incremented value. A match on B does not clear the count in this mode.
- R6: With control bits 4:3 = 10, a counting cycle with a match on compare B loads 0x00 instead of the incremented value. A match on A does not clear the count in this mode.
- R7: With control bits 4:3 = 11, a rising edge on `ext_clr` clears the count at the third clock edge after the pin goes high. A pin that stays high, a falling edge, or any pin activity in another mode leaves the count unchanged.
- R8: Each interrupt output is high exactly while its flag and its enable are both 1. `irq_cmp_b` uses enable bit 7 and status bit 7. `irq_cmp_a` uses enable bit 6 and status bit 6. `irq_ovf` uses enable bit 5 and status bit 5.
- R9: A flag is cleared by writing 0 to its status bit after a status read that returned it as 1. Writing 0 without that read, or writing 1, leaves the flag unchanged.
- R10: When a flag's set event and its clearing write fall in the same cycle, the flag stays set.
- R11: The bus map is 0 control, 1 status, 2 count, 3 compare A, 4 compare B. Unused bits of control (2:0) and status (4:0) read 0. A write to the count loads the written value and overrides counting and clearing in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable, one step per high cycle |
| ext_clr | input | 1 | Asynchronous external clear pin |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used to arm flag clearing |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the selected register |
| irq_cmp_b | output | 1 | Compare B interrupt level |
| irq_cmp_a | output | 1 | Compare A interrupt level |
| irq_ovf | output | 1 | Overflow interrupt level |

## Verification
The counting path is run in all four clear modes. Free running from a loaded 0xFE shows that a wrap sets overflow and no compare flag. The same short count sequence in modes 01 and 10, with both compare values inside the range, shows that only the selected compare clears the count and the other only flags. In mode 11, the pin is held high, dropped, and toggled in mode 00, which separates edge detection from level sensing and confirms the three-edge latency. The flag protocol is tried with write-0 without a read, with write-1, with a proper read-then-write, and with a write that coincides with a fresh match, which tells the arming rule and set priority apart.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_STAT = 3'd1,
        RA_CNT  = 3'd2,
        RA_CMPA = 3'd3,
        RA_CMPB = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_ON_EXT = 2'b11
    } clr_mode_e;

    // control field positions
    localparam int CTL_IE_B   = 7;
    localparam int CTL_IE_A   = 6;
    localparam int CTL_IE_OVF = 5;
    localparam int CTL_MODE_HI = 4;
    localparam int CTL_MODE_LO = 3;

    // flag vector order {B, A, overflow} lands on status bits 7:5
    localparam int NUM_FLAGS = 3;
    localparam int STAT_LO   = 5;
    localparam int FLG_OVF = 0;
    localparam int FLG_A   = 1;
    localparam int FLG_B   = 2;

endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin};
        st_d.last  = st_q.chain[STAGES-1];
        rise = st_q.chain[STAGES-1] & ~st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  clr_mode_e    clr_mode,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         ext_rise,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         hit_a,
    output logic         hit_b,
    output logic         wrap
);

    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic active;
    logic ext_clr;
    logic match_clr;

    always_comb begin
        st_d      = st_q;
        active    = cnt_en & ~load;
        hit_a     = active & (st_q.cnt == cmp_a);
        hit_b     = active & (st_q.cnt == cmp_b);
        ext_clr   = ext_rise & (clr_mode == CLR_ON_EXT);
        match_clr = ((clr_mode == CLR_ON_A) & hit_a) |
                    ((clr_mode == CLR_ON_B) & hit_b);
        wrap      = active & ~ext_clr & ~match_clr & (st_q.cnt == TOP);

        if (load) begin
            st_d.cnt = load_val;
        end else if (ext_clr) begin
            st_d.cnt = '0;
        end else if (active) begin
            st_d.cnt = match_clr ? '0 : st_q.cnt + ONE;
        end
        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [W-1:0]         bus_wdata,
    output logic [W-1:0]         bus_rdata,
    input  logic [W-1:0]         count,
    input  logic                 hit_a,
    input  logic                 hit_b,
    input  logic                 wrap,
    output clr_mode_e            clr_mode,
    output logic [W-1:0]         cmp_a,
    output logic [W-1:0]         cmp_b,
    output logic                 cnt_load,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] enables
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] ie;
        clr_mode_e            mode;
        logic [W-1:0]         cmp_a;
        logic [W-1:0]         cmp_b;
        logic [NUM_FLAGS-1:0] flg;
        logic [NUM_FLAGS-1:0] armed;
    } regs_t;

    regs_t st_d, st_q;

    logic                 wr_ctrl, wr_stat, rd_stat;
    logic [NUM_FLAGS-1:0] events;
    logic [NUM_FLAGS-1:0] clr_mask;
    logic                 unused_wbits;

    assign unused_wbits = ^{bus_wdata[CTL_MODE_LO-1:0], bus_wdata[W-1:8]};

    always_comb begin
        st_d     = st_q;
        wr_ctrl  = bus_wr & (bus_addr == RA_CTRL);
        wr_stat  = bus_wr & (bus_addr == RA_STAT);
        rd_stat  = bus_rd & (bus_addr == RA_STAT);
        cnt_load = bus_wr & (bus_addr == RA_CNT);

        events = '0;
        events[FLG_B]   = hit_b;
        events[FLG_A]   = hit_a;
        events[FLG_OVF] = wrap;

        if (wr_ctrl) begin
            st_d.ie   = bus_wdata[CTL_IE_B:CTL_IE_OVF];
            st_d.mode = clr_mode_e'(bus_wdata[CTL_MODE_HI:CTL_MODE_LO]);
        end
        if (bus_wr && bus_addr == RA_CMPA) begin
            st_d.cmp_a = bus_wdata;
        end
        if (bus_wr && bus_addr == RA_CMPB) begin
            st_d.cmp_b = bus_wdata;
        end

        // clearing needs a prior read that saw the flag high; set wins
        clr_mask = wr_stat ? (st_q.armed & ~bus_wdata[STAT_LO+NUM_FLAGS-1:STAT_LO])
                           : '0;
        st_d.flg = (st_q.flg & ~clr_mask) | events;

        st_d.armed = st_q.armed;
        if (rd_stat) begin
            st_d.armed = st_d.armed | st_q.flg;
        end
        st_d.armed = st_d.armed & st_d.flg;

        bus_rdata = '0;
        unique case (bus_addr)
            RA_CTRL: bus_rdata[7:0] = {st_q.ie, st_q.mode, 3'b000};
            RA_STAT: bus_rdata[7:0] = {st_q.flg, 5'b00000};
            RA_CNT:  bus_rdata = count;
            RA_CMPA: bus_rdata = st_q.cmp_a;
            RA_CMPB: bus_rdata = st_q.cmp_b;
            default: bus_rdata = '0;
        endcase
    end

    assign clr_mode = st_q.mode;
    assign cmp_a    = st_q.cmp_a;
    assign cmp_b    = st_q.cmp_b;
    assign flags    = st_q.flg;
    assign enables  = st_q.ie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= CLR_NONE;
            st_q.cmp_a <= '1;
            st_q.cmp_b <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dual_cmp_timer.sv
`timescale 1ns/1ps
module dual_cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              ext_clr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_cmp_b,
    output logic              irq_cmp_a,
    output logic              irq_ovf
);

    logic                 ext_rise;
    logic [CNT_W-1:0]     cnt_val, cmp_a, cmp_b;
    logic                 hit_a, hit_b, wrap, cnt_load;
    clr_mode_e            clr_mode;
    logic [NUM_FLAGS-1:0] flags, enables, irq_vec;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_clr),
        .rise (ext_rise)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .clr_mode(clr_mode),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .ext_rise(ext_rise),
        .load    (cnt_load),
        .load_val(bus_wdata),
        .count   (cnt_val),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .wrap    (wrap)
    );

    tmr_regs #(.W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .count    (cnt_val),
        .hit_a    (hit_a),
        .hit_b    (hit_b),
        .wrap     (wrap),
        .clr_mode (clr_mode),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .cnt_load (cnt_load),
        .flags    (flags),
        .enables  (enables)
    );

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_irq
            assign irq_vec[i] = flags[i] & enables[i];
        end
    endgenerate

    assign irq_cmp_b = irq_vec[FLG_B];
    assign irq_cmp_a = irq_vec[FLG_A];
    assign irq_ovf   = irq_vec[FLG_OVF];

endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_en,
    input logic                 cnt_load,
    input logic                 stat_wr,
    input logic [W-1:0]         count,
    input logic                 hit_a,
    input logic                 hit_b,
    input logic                 wrap,
    input logic [1:0]           mode,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 irq_b,
    input logic                 irq_a,
    input logic                 irq_o
);

    localparam logic [W-1:0] ONE = W'(1);

    AST_HIT_A_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> flags[FLG_A]); // R3
    AST_HIT_B_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> flags[FLG_B]); // R3
    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flags[FLG_OVF]); // R4
    AST_FREE_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_load && mode == 2'b00) |=> (count == $past(count) + ONE)); // R2
    AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && mode == 2'b01) |=> (count == '0)); // R5
    AST_CLEAR_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b && mode == 2'b10) |=> (count == '0)); // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_A] && !stat_wr) |=> flags[FLG_A]); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_b || irq_a || irq_o) |-> (flags != '0)); // R8

endmodule

bind dual_cmp_timer tmr_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .cnt_load(cnt_load),
    .stat_wr (bus_wr && bus_addr == tmr_pkg::RA_STAT),
    .count   (cnt_val),
    .hit_a   (hit_a),
    .hit_b   (hit_b),
    .wrap    (wrap),
    .mode    (clr_mode),
    .flags   (flags),
    .irq_b   (irq_cmp_b),
    .irq_a   (irq_cmp_a),
    .irq_o   (irq_ovf)
);

// File: tb/dual_cmp_timer_test.sv
`timescale 1ns/1ps
module dual_cmp_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       ext_clr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_cmp_b, irq_cmp_a, irq_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_clr(ext_clr),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_cmp_b(irq_cmp_b), .irq_cmp_a(irq_cmp_a), .irq_ovf(irq_ovf)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=0x%02h exp=0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic count_n(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic clear_flags();
        logic [7:0] d;
        rd(3'd1, d);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd0, d); check("R1 ctrl", d, 8'h00);
        rd(3'd1, d); check("R1 status", d, 8'h00);
        rd(3'd2, d); check("R1 count", d, 8'h00);
        rd(3'd3, d); check("R1 cmpA", d, 8'hFF);
        rd(3'd4, d); check("R1 cmpB", d, 8'hFF);
        check("R1 irqs", {5'd0, irq_cmp_b, irq_cmp_a, irq_ovf}, 8'h00);
    endtask

    task automatic t_count();
        logic [7:0] d;
        count_n(10);
        rd(3'd2, d); check("R2 count 10", d, 8'd10);
        repeat (5) @(negedge clk);
        rd(3'd2, d); check("R2 hold", d, 8'd10);
    endtask

    task automatic t_match_a();
        logic [7:0] d;
        wr(3'd3, 8'd5);
        wr(3'd2, 8'd0);
        count_n(5);
        rd(3'd1, d); check("R3 no flag before match", d, 8'h00);
        count_n(1);
        rd(3'd2, d); check("R3 count 6", d, 8'd6);
        rd(3'd1, d); check("R3 flag A", d, 8'h40);
        check("R8 irq_a disabled", {7'd0, irq_cmp_a}, 8'd0);
        wr(3'd0, 8'h40);
        #1 check("R8 irq_a enabled", {7'd0, irq_cmp_a}, 8'd1);
        wr(3'd1, 8'h00);
        rd(3'd1, d); check("R9 read-then-clear", d, 8'h00);
        check("R8 irq_a drops", {7'd0, irq_cmp_a}, 8'd0);
    endtask

    task automatic t_flag_protocol();
        logic [7:0] d;
        wr(3'd4, 8'd3);
        wr(3'd2, 8'd0);
        count_n(4);
        check("R8 irq_b disabled", {7'd0, irq_cmp_b}, 8'd0);
        wr(3'd1, 8'h00);
        rd(3'd1, d); check("R9 write0 without read", d, 8'h80);
        wr(3'd1, 8'hFF);
        rd(3'd1, d); check("R9 write1 no effect", d, 8'h80);
        wr(3'd1, 8'h00);
        rd(3'd1, d); check("R9 proper clear", d, 8'h00);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        clear_flags();
        wr(3'd2, 8'hFE);
        count_n(2);
        rd(3'd2, d); check("R2 wrap to 0", d, 8'h00);
        rd(3'd1, d); check("R4 overflow flag", d, 8'h20);
        wr(3'd0, 8'h20);
        #1 check("R8 irq_ovf", {5'd0, irq_cmp_b, irq_cmp_a, irq_ovf}, 8'h01);
        wr(3'd0, 8'h00);
        #1 check("R8 irq_ovf off by enable", {7'd0, irq_ovf}, 8'd0);
        clear_flags();
    endtask

    task automatic t_mode_a();
        logic [7:0] d;
        wr(3'd0, 8'h08);
        wr(3'd3, 8'd4);
        wr(3'd4, 8'd3);
        wr(3'd2, 8'd0);
        count_n(5);
        rd(3'd2, d); check("R5 clear on A", d, 8'd0);
        count_n(2);
        rd(3'd2, d); check("R5 restart", d, 8'd2);
    endtask

    task automatic t_mode_b();
        logic [7:0] d;
        wr(3'd0, 8'h10);
        wr(3'd4, 8'd2);
        wr(3'd3, 8'd1);
        wr(3'd2, 8'd0);
        count_n(3);
        rd(3'd2, d); check("R6 clear on B", d, 8'd0);
        count_n(4);
        rd(3'd2, d); check("R6 A no clear", d, 8'd1);
        clear_flags();
    endtask

    task automatic t_mode_ext();
        logic [7:0] d;
        wr(3'd0, 8'h18);
        wr(3'd2, 8'h30);
        @(negedge clk); ext_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 not yet", bus_rdata, 8'h30);
        @(negedge clk);
        check("R7 cleared third edge", bus_rdata, 8'h00);
        wr(3'd2, 8'h40);
        repeat (5) @(negedge clk);
        rd(3'd2, d); check("R7 steady high", d, 8'h40);
        ext_clr = 1'b0;
        repeat (5) @(negedge clk);
        rd(3'd2, d); check("R7 falling edge", d, 8'h40);
        wr(3'd0, 8'h00);
        ext_clr = 1'b1;
        repeat (5) @(negedge clk);
        ext_clr = 1'b0;
        rd(3'd2, d); check("R7 other mode ignores pin", d, 8'h40);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        wr(3'd3, 8'h10);
        wr(3'd2, 8'h10);
        count_n(1);
        rd(3'd1, d); check("R3 flag A set", d & 8'h40, 8'h40);
        wr(3'd2, 8'h10);
        @(negedge clk);
        cnt_en = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0; bus_wr = 1'b0;
        rd(3'd1, d); check("R10 set wins", d & 8'h40, 8'h40);
        wr(3'd1, 8'h00);
        rd(3'd1, d); check("R9 later clear", d & 8'h40, 8'h00);
    endtask

    task automatic t_map_load();
        logic [7:0] d;
        wr(3'd0, 8'hFF);
        rd(3'd0, d); check("R11 ctrl unused bits", d, 8'hF8);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h20);
        @(negedge clk);
        cnt_en = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h77; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        cnt_en = 1'b0;
        rd(3'd2, d); check("R11 load overrides count", d, 8'h78);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_match_a();
        t_flag_protocol();
        t_overflow();
        t_mode_a();
        t_mode_b();
        t_mode_ext();
        t_set_wins();
        t_map_load();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule